// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects every interrupt request that a small CPU core can see: a group of serial-port events, a row of other on-chip peripheral requests, an external non-maskable request, an illegal-opcode trap and a software interrupt. It gates each request with its local enable and with one of two mask bits held inside the block. Among the requests that survive, it picks a single winner and presents that winner's 16-bit vector address to the CPU on a registered output.

Maskable requests obey a global interrupt mask bit (I). The external non-maskable request obeys a separate bit (X). Software can clear X but can never set it again. Reset sets both bits. When the CPU acknowledges a pending request, the block latches the presented vector and sets I. If the accepted request was the external non-maskable one, it also sets X.

Vectors sit at even addresses. Nothing is ever produced in the reserved span 0xFFC0 to 0xFFD5. Register stacking inside the CPU and the peripherals that raise the requests are outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `irq_pend` is 0, `irq_vec` and `taken_vec` are 0x0000, and `mask_i` and `mask_x` are both 1.
- R2: The three non-maskable sources rank as follows: `illop_req` (0xFFF8) first, then `swi_req` (0xFFF6), then the external request `nmi_req` (0xFFF4). Every non-maskable source outranks every maskable one, and none of them depends on `mask_i` or on any local enable.
- R3: `nmi_req` is honoured only while `mask_x` is 0. A mask write (`mask_wr`=1) may clear `mask_x` with `mask_x_in`=0. A write with `mask_x_in`=1 leaves `mask_x` unchanged.
- R4: Acknowledging the external request sets `mask_x` to 1. Acknowledging any other source leaves `mask_x` unchanged.
- R5: While `mask_i` is 1, no serial event and no `per_req` bit can make `irq_pend` high. A mask write loads `mask_i` from `mask_i_in`.
- R6: `per_req[k]` counts as pending only when `per_en[k]` is 1.
- R7: The serial events share vector 0xFFD6. Each event has its own enable: `ser_evt[0]` with `ser_en[0]`, `ser_evt[1]` with `ser_en[1]`, `ser_evt[2]` with `ser_en[2]`, and both `ser_evt[3]` and `ser_evt[4]` with `ser_en[3]`.
- R8: Peripheral source k has vector 0xFFD8 + 2k. Among maskable sources the higher vector wins, so the serial group ranks lowest.
- R9: When `ack` is high on a clock edge while `irq_pend` is high, the edge copies `irq_vec` into `taken_vec` and sets `mask_i`. When `ack` is high while nothing is pending, it changes neither `taken_vec` nor the masks.
- R10: `irq_vec` and `irq_pend` are registered and follow the inputs one clock later. With nothing pending, `irq_vec` is 0x0000. When something is pending, `irq_vec` is even and at least 0xFFD6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_evt | input | 5 | Serial event flags sharing one vector |
| ser_en | input | 4 | Serial event enables (bit 3 covers events 3 and 4) |
| per_req | input | NUM_SRC | Peripheral request lines |
| per_en | input | NUM_SRC | Per-peripheral enables |
| nmi_req | input | 1 | External non-maskable request |
| illop_req | input | 1 | Illegal-opcode trap |
| swi_req | input | 1 | Software interrupt |
| mask_wr | input | 1 | Mask write strobe |
| mask_i_in | input | 1 | New value for the global mask |
| mask_x_in | input | 1 | Value ANDed into the external-request mask |
| ack | input | 1 | CPU accepts the presented vector |
| irq_pend | output | 1 | A request is pending |
| irq_vec | output | 16 | Vector address of the current winner |
| taken_vec | output | 16 | Vector latched by the last accepted acknowledge |
| mask_i | output | 1 | Global mask bit |
| mask_x | output | 1 | External-request mask bit |

## Verification
The bench drives the external request together with other sources to check its rank. A design that ordered the three non-maskable sources wrongly, or let I block them, would present the wrong vector. It writes 1 to X after clearing it; a controller that let software set X again would shut out the external request. It acknowledges both the external request and an ordinary source, to catch X being set on the wrong acceptance. It routes receive-full and overrun through their shared enable, and sweeps every peripheral index to expose wrong vector arithmetic or a reversed priority. It also acknowledges with nothing pending, to catch a controller that latches stale vectors or sets I anyway.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int VW = 16;
  localparam logic [VW-1:0] VEC_NONE     = 16'h0000;
  localparam logic [VW-1:0] VEC_ILLOP    = 16'hFFF8;
  localparam logic [VW-1:0] VEC_SWI      = 16'hFFF6;
  localparam logic [VW-1:0] VEC_NMI      = 16'hFFF4;
  localparam logic [VW-1:0] VEC_SER      = 16'hFFD6;
  localparam logic [VW-1:0] VEC_GEN_BASE = 16'hFFD8;
  localparam logic [VW-1:0] VEC_RSV_TOP  = 16'hFFD5;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_SER, WIN_GEN, WIN_NMI, WIN_SWI, WIN_ILLOP
  } win_t;
endpackage

// File: rtl/ivc_ser_gate.sv
module ivc_ser_gate #(
  parameter int N_EVT = 5,
  parameter int N_EN  = 4
) (
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EN-1:0]  en,
  output logic             any
);
  logic [N_EVT-1:0] gated;

  // events beyond the last enable all share the final enable bit
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    localparam int EI = (g < N_EN) ? g : N_EN - 1;
    assign gated[g] = evt[g] & en[EI];
  end

  assign any = |gated;
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int N  = 14,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // highest index wins
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        valid = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/ivc_mask.sv
module ivc_mask (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic i_in,
  input  logic x_in,
  input  logic take,
  input  logic take_nmi,
  output logic i_q,
  output logic x_q
);
  logic i_d, x_d;

  always_comb begin
    i_d = i_q;
    x_d = x_q;
    if (wr) begin
      i_d = i_in;
      x_d = x_q & x_in;
    end
    if (take) begin
      i_d = 1'b1;
      if (take_nmi) x_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_q <= 1'b1;
      x_q <= 1'b1;
    end else begin
      i_q <= i_d;
      x_q <= x_d;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int SER_EVT = 5,
  parameter int SER_EN  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SER_EVT-1:0] ser_evt,
  input  logic [SER_EN-1:0]  ser_en,
  input  logic [NUM_SRC-1:0] per_req,
  input  logic [NUM_SRC-1:0] per_en,
  input  logic               nmi_req,
  input  logic               illop_req,
  input  logic               swi_req,
  input  logic               mask_wr,
  input  logic               mask_i_in,
  input  logic               mask_x_in,
  input  logic               ack,
  output logic               irq_pend,
  output logic [VW-1:0]      irq_vec,
  output logic [VW-1:0]      taken_vec,
  output logic               mask_i,
  output logic               mask_x
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic          ser_any;
  logic          gen_valid;
  logic [IW-1:0] gen_idx;
  logic [NUM_SRC-1:0] gen_live;
  win_t          win;
  logic [VW-1:0] win_vec;
  logic          take;
  logic          took_nmi_q;

  ivc_ser_gate #(.N_EVT(SER_EVT), .N_EN(SER_EN)) u_ser (
    .evt (ser_evt),
    .en  (ser_en),
    .any (ser_any)
  );

  assign gen_live = per_req & per_en;

  ivc_pick #(.N(NUM_SRC)) u_pick (
    .req   (gen_live),
    .valid (gen_valid),
    .idx   (gen_idx)
  );

  always_comb begin
    win = WIN_NONE;
    if (illop_req)                   win = WIN_ILLOP;
    else if (swi_req)                win = WIN_SWI;
    else if (nmi_req && !mask_x)     win = WIN_NMI;
    else if (!mask_i && gen_valid)   win = WIN_GEN;
    else if (!mask_i && ser_any)     win = WIN_SER;
  end

  always_comb begin
    unique case (win)
      WIN_ILLOP: win_vec = VEC_ILLOP;
      WIN_SWI:   win_vec = VEC_SWI;
      WIN_NMI:   win_vec = VEC_NMI;
      WIN_GEN:   win_vec = VEC_GEN_BASE + VW'({gen_idx, 1'b0});
      WIN_SER:   win_vec = VEC_SER;
      default:   win_vec = VEC_NONE;
    endcase
  end

  assign take = ack & irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend   <= 1'b0;
      irq_vec    <= VEC_NONE;
      took_nmi_q <= 1'b0;
      taken_vec  <= VEC_NONE;
    end else begin
      irq_pend   <= (win != WIN_NONE);
      irq_vec    <= win_vec;
      took_nmi_q <= (win == WIN_NMI);
      if (take) taken_vec <= irq_vec;
    end
  end

  ivc_mask u_mask (
    .clk      (clk),
    .rst      (rst),
    .wr       (mask_wr),
    .i_in     (mask_i_in),
    .x_in     (mask_x_in),
    .take     (take),
    .take_nmi (took_nmi_q),
    .i_q      (mask_i),
    .x_q      (mask_x)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import ivc_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          illop_req,
  input logic          irq_pend,
  input logic [VW-1:0] irq_vec,
  input logic [VW-1:0] taken_vec,
  input logic          mask_i,
  input logic          mask_x
);
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_pend |-> irq_vec == VEC_NONE); // R10
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (irq_vec > VEC_RSV_TOP && !irq_vec[0])); // R10
  AST_ACK_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_pend) |=> taken_vec == $past(irq_vec)); // R9
  AST_ACK_SETS_I: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_pend) |=> mask_i); // R9
  AST_TAKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ack && irq_pend) |=> $stable(taken_vec)); // R9
  AST_X_SET_ONLY_BY_NMI: assert property (@(posedge clk) disable iff (rst)
    $rose(mask_x) |-> $past(ack && irq_pend && irq_vec == VEC_NMI)); // R4
  AST_ILLOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(illop_req)) |-> irq_vec == VEC_ILLOP); // R2
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .illop_req (illop_req),
  .irq_pend  (irq_pend),
  .irq_vec   (irq_vec),
  .taken_vec (taken_vec),
  .mask_i    (mask_i),
  .mask_x    (mask_x)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] ser_evt = '0;
  logic [3:0] ser_en = '0;
  logic [NS-1:0] per_req = '0;
  logic [NS-1:0] per_en = '0;
  logic nmi_req = 1'b0, illop_req = 1'b0, swi_req = 1'b0;
  logic mask_wr = 1'b0, mask_i_in = 1'b0, mask_x_in = 1'b0, ack = 1'b0;
  logic irq_pend, mask_i, mask_x;
  logic [15:0] irq_vec, taken_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(NS)) uut (
    .clk(clk), .rst(rst), .ser_evt(ser_evt), .ser_en(ser_en),
    .per_req(per_req), .per_en(per_en), .nmi_req(nmi_req),
    .illop_req(illop_req), .swi_req(swi_req), .mask_wr(mask_wr),
    .mask_i_in(mask_i_in), .mask_x_in(mask_x_in), .ack(ack),
    .irq_pend(irq_pend), .irq_vec(irq_vec), .taken_vec(taken_vec),
    .mask_i(mask_i), .mask_x(mask_x)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet();
    ser_evt = '0; ser_en = '0; per_req = '0; per_en = '0;
    nmi_req = 0; illop_req = 0; swi_req = 0;
  endtask

  task automatic wr_mask(logic i, logic x);
    mask_wr = 1; mask_i_in = i; mask_x_in = x;
    @(negedge clk);
    mask_wr = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 pend", 16'(irq_pend), 16'd0);
    chk("R1 vec", irq_vec, 16'h0000);
    chk("R1 taken", taken_vec, 16'h0000);
    chk("R1 I", 16'(mask_i), 16'd1);
    chk("R1 X", 16'(mask_x), 16'd1);
    per_req = '1; per_en = '1; ser_evt = '1; ser_en = '1; nmi_req = 1;
    step();
    chk("R5 masked after reset", 16'(irq_pend), 16'd0);
    chk("R3 X masks external", irq_vec, 16'h0000);
    quiet(); step();
  endtask

  task automatic t_nonmask();
    swi_req = 1; step();
    chk("R2 swi vector", irq_vec, 16'hFFF6);
    illop_req = 1; step();
    chk("R2 illop over swi", irq_vec, 16'hFFF8);
    quiet();
    wr_mask(1'b1, 1'b0);
    nmi_req = 1; swi_req = 1; step();
    chk("R2 swi over external", irq_vec, 16'hFFF6);
    swi_req = 0; step();
    chk("R3 external after X clear", irq_vec, 16'hFFF4);
    wr_mask(1'b0, 1'b0);
    per_req = '1; per_en = '1; ser_evt = '1; ser_en = '1; step();
    chk("R2 external over maskable", irq_vec, 16'hFFF4);
    quiet(); step();
  endtask

  task automatic t_xsticky();
    wr_mask(1'b0, 1'b1);
    @(negedge clk);
    chk("R3 X not settable", 16'(mask_x), 16'd0);
    nmi_req = 1; step();
    chk("R3 external pending", irq_vec, 16'hFFF4);
    do_ack();
    chk("R4 X set by external ack", 16'(mask_x), 16'd1);
    chk("R9 I set by ack", 16'(mask_i), 16'd1);
    chk("R9 taken external", taken_vec, 16'hFFF4);
    step();
    chk("R3 external now masked", 16'(irq_pend), 16'd0);
    nmi_req = 0;
    wr_mask(1'b1, 1'b0);
    swi_req = 1; step();
    do_ack();
    chk("R4 X kept by swi ack", 16'(mask_x), 16'd0);
    chk("R9 taken swi", taken_vec, 16'hFFF6);
    quiet(); step();
  endtask

  task automatic t_generic();
    wr_mask(1'b0, 1'b0);
    for (int k = 0; k < NS; k++) begin
      per_req = '0; per_en = '0;
      per_req[k] = 1; per_en[k] = 1; step();
      chk("R8 peripheral vector", irq_vec, 16'hFFD8 + 16'(2 * k));
    end
    per_req = '0; per_en = '0;
    per_req[2] = 1; per_req[7] = 1; per_en = '1; step();
    chk("R8 higher peripheral wins", irq_vec, 16'hFFE6);
    per_en = '0; per_en[2] = 1; step();
    chk("R6 disabled peripheral ignored", irq_vec, 16'hFFDC);
    per_en = '0; step();
    chk("R6 no enables no pend", 16'(irq_pend), 16'd0);
    chk("R10 idle vec zero", irq_vec, 16'h0000);
    quiet(); step();
  endtask

  task automatic t_serial();
    for (int e = 0; e < 5; e++) begin
      ser_evt = '0; ser_en = '0;
      ser_evt[e] = 1;
      ser_en[(e < 4) ? e : 3] = 1; step();
      chk("R7 serial event vector", irq_vec, 16'hFFD6);
    end
    ser_evt = 5'b10000; ser_en = 4'b0111; step();
    chk("R7 rx full needs shared enable", 16'(irq_pend), 16'd0);
    ser_evt = 5'b00001; ser_en = 4'b1110; step();
    chk("R7 tx complete own enable", 16'(irq_pend), 16'd0);
    ser_evt = 5'b00001; ser_en = 4'b0001; per_req[0] = 1; per_en[0] = 1; step();
    chk("R8 serial ranks lowest", irq_vec, 16'hFFD8);
    quiet(); step();
  endtask

  task automatic t_ack();
    per_req[3] = 1; per_en[3] = 1; step();
    do_ack();
    chk("R9 taken peripheral", taken_vec, 16'hFFDE);
    chk("R9 I after ack", 16'(mask_i), 16'd1);
    step();
    chk("R5 I blocks peripheral", 16'(irq_pend), 16'd0);
    quiet();
    wr_mask(1'b0, 1'b0);
    step();
    do_ack();
    chk("R9 idle ack keeps taken", taken_vec, 16'hFFDE);
    chk("R9 idle ack keeps I", 16'(mask_i), 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_nonmask();
    t_xsticky();
    t_generic();
    t_serial();
    t_ack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule